// File: doc/BRIEF.md
# Write-Protection and One-Time-Page Lock Unit

This unit sits beside the serial bus slave controller of a serial memory and makes the yes/no decision for every data byte that a host tries to write. For each byte it looks at the target region (main array, one-time page, control register), the byte address, the two protection pins and the current control-register settings, and it drives an acknowledge-enable for that byte. Bytes that are refused get no acknowledge and are not stored. Device-select and address bytes are handled by the controller and are not gated here.

The unit also tracks each write transaction. When the host ends a transaction with a stop, it raises a one-cycle commit enable if at least one data byte of that transaction was accepted. A flag records that the 32-byte one-time page has been programmed. The flag sets only when a program of that page really commits. After that, every later write to the page is refused.

Top module: `wprot_unit`

## Requirements
- R1: A data byte to the main array (region code 2'b00) is acknowledged (`data_ack_en`=1) when write-control is inactive and the byte address lies outside the read-only zone.
- R2: With `ctl_wc_pol`=0 the write-control pin is active when high. With `ctl_wc_pol`=1 it is active when low. A pin held low (which is also how a floating pin reads) with polarity 0 leaves writes enabled.
- R3: While write-control is active, data bytes to the main array and to the one-time page (region code 2'b01) are refused. Bytes to the control register (region code 2'b10) are unaffected.
- R4: Control-register bytes are accepted when `ctl_cr_lock`=0, whatever `crw_pin` is. When `ctl_cr_lock`=1 they are accepted only while `crw_pin`=1.
- R5: The read-only zone covers the top `ctl_ro_blocks` blocks of 512 bytes of the 4096-byte main array. A value of 0 protects nothing. Values of 8 or more protect the whole array. Bytes whose address falls in the zone are refused.
- R6: `commit_en` goes high for exactly one cycle in the cycle after the one in which `txn_stop` is sampled, and only if at least one data byte of that transaction was acknowledged. `txn_start` begins a new transaction with nothing pending.
- R7: `otp_used` goes high in the same cycle as the `commit_en` of a transaction that wrote the one-time page. A transaction whose page bytes were all refused leaves the flag low. Once the flag is set, page bytes are refused, and the flag stays set until reset.
- R8: A synchronous reset clears `commit_en` and any pending transaction, and loads `otp_used` from the parameter `OTP_INIT` (default 0).
- R9: Region code 2'b11 is unused. Data bytes sent to it are never acknowledged and never cause a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| region_sel | input | 2 | Target region: 00 main, 01 one-time page, 10 control register, 11 unused |
| byte_addr | input | ADDR_W (12) | Byte address within the main array |
| wc_pin | input | 1 | Write-control pin level (low when unconnected) |
| crw_pin | input | 1 | Control-register write-enable pin level |
| ctl_wc_pol | input | 1 | Write-control polarity: 0 active-high, 1 active-low |
| ctl_cr_lock | input | 1 | Control-register lock bit |
| ctl_ro_blocks | input | BLKCNT_W (4) | Number of 512-byte blocks protected from the top of the array |
| txn_start | input | 1 | Start of a write transaction |
| byte_strobe | input | 1 | A data byte is at its acknowledge slot |
| txn_stop | input | 1 | Stop condition ending the transaction |
| data_ack_en | output | 1 | Acknowledge-enable for the current data byte |
| commit_en | output | 1 | One-cycle enable to start the internal write cycle |
| otp_used | output | 1 | One-time page has been programmed |

## Verification
A wrong pending bit inside the transaction tracker shows at the ports in the cycle after the stop. It appears as a missing or extra `commit_en` pulse, and for page writes also as a wrong `otp_used`. A wrong one-time flag shows up at once: the next page byte is acknowledged when it should not be, or refused when it should be accepted. The zone and polarity logic has no state of its own, so any fault there is visible on `data_ack_en` in the same cycle the byte is presented. The bench therefore sweeps addresses across each block boundary and every pin and polarity combination.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        RGN_MAIN = 2'b00,
        RGN_OTP  = 2'b01,
        RGN_CTRL = 2'b10,
        RGN_NONE = 2'b11
    } region_e;

    typedef struct packed {
        logic wc_pol;
        logic cr_lock;
    } ctl_flags_t;

    typedef struct packed {
        logic    pending;
        logic    touched_otp;
    } txn_state_t;

    // Effective write-control level after polarity selection.
    function automatic logic wc_is_active(input logic pin, input logic pol);
        return pol ? ~pin : pin;
    endfunction

    // Control register writable unless locked and its pin is low.
    function automatic logic ctrl_writable(input logic lock, input logic pin);
        return ~lock | pin;
    endfunction

endpackage

// File: rtl/wp_region_gate.sv
module wp_region_gate
    import wp_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BLK_SHIFT = 9,
    parameter int BLKCNT_W  = 4
) (
    input  region_e              region,
    input  logic [ADDR_W-1:0]    byte_addr,
    input  logic                 wc_pin,
    input  logic                 crw_pin,
    input  ctl_flags_t           flags,
    input  logic [BLKCNT_W-1:0]  ro_blocks,
    input  logic                 otp_used,
    output logic                 byte_ok
);
    localparam int NBLK  = 1 << (ADDR_W - BLK_SHIFT);
    localparam int SUM_W = ((ADDR_W > BLKCNT_W) ? ADDR_W : BLKCNT_W) + 1;

    logic [ADDR_W-1:0] blk_idx;
    logic [SUM_W-1:0]  blk_sum;
    logic              in_zone;
    logic              wc_act;

    always_comb begin
        blk_idx = byte_addr >> BLK_SHIFT;
        blk_sum = SUM_W'(blk_idx) + SUM_W'(ro_blocks);
        in_zone = blk_sum >= SUM_W'(NBLK);
        wc_act  = wc_is_active(wc_pin, flags.wc_pol);
    end

    always_comb begin
        unique case (region)
            RGN_MAIN: byte_ok = ~wc_act & ~in_zone;
            RGN_OTP:  byte_ok = ~wc_act & ~otp_used;
            RGN_CTRL: byte_ok = ctrl_writable(flags.cr_lock, crw_pin);
            default:  byte_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/wp_txn_track.sv
module wp_txn_track
    import wp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    txn_start,
    input  logic    byte_strobe,
    input  logic    byte_ok,
    input  logic    txn_stop,
    input  region_e region,
    output logic    commit_en,
    output logic    otp_commit_now
);
    txn_state_t st_q, st_d;
    logic       commit_q;

    always_comb begin
        st_d = st_q;
        if (txn_start || txn_stop) begin
            st_d = '0;
        end else if (byte_strobe && byte_ok) begin
            st_d.pending = 1'b1;
            if (region == RGN_OTP) st_d.touched_otp = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            commit_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            commit_q <= txn_stop & st_q.pending;
        end
    end

    assign commit_en      = commit_q;
    assign otp_commit_now = txn_stop & st_q.pending & st_q.touched_otp;

endmodule

// File: rtl/wp_otp_flag.sv
module wp_otp_flag #(
    parameter bit OTP_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_now,
    output logic used
);
    logic used_q;

    always_ff @(posedge clk) begin
        if (rst) used_q <= OTP_INIT;
        else     used_q <= used_q | set_now;
    end

    assign used = used_q;

endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wp_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BLK_SHIFT = 9,
    parameter bit OTP_INIT  = 1'b0,
    localparam int BLKCNT_W = $clog2((1 << (ADDR_W - BLK_SHIFT)) + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          region_sel,
    input  logic [ADDR_W-1:0]   byte_addr,
    input  logic                wc_pin,
    input  logic                crw_pin,
    input  logic                ctl_wc_pol,
    input  logic                ctl_cr_lock,
    input  logic [BLKCNT_W-1:0] ctl_ro_blocks,
    input  logic                txn_start,
    input  logic                byte_strobe,
    input  logic                txn_stop,
    output logic                data_ack_en,
    output logic                commit_en,
    output logic                otp_used
);
    region_e    region;
    ctl_flags_t flags;
    logic       byte_ok;
    logic       otp_set;

    assign region        = region_e'(region_sel);
    assign flags.wc_pol  = ctl_wc_pol;
    assign flags.cr_lock = ctl_cr_lock;

    wp_region_gate #(
        .ADDR_W    (ADDR_W),
        .BLK_SHIFT (BLK_SHIFT),
        .BLKCNT_W  (BLKCNT_W)
    ) u_gate (
        .region    (region),
        .byte_addr (byte_addr),
        .wc_pin    (wc_pin),
        .crw_pin   (crw_pin),
        .flags     (flags),
        .ro_blocks (ctl_ro_blocks),
        .otp_used  (otp_used),
        .byte_ok   (byte_ok)
    );

    wp_txn_track u_txn (
        .clk            (clk),
        .rst            (rst),
        .txn_start      (txn_start),
        .byte_strobe    (byte_strobe),
        .byte_ok        (byte_ok),
        .txn_stop       (txn_stop),
        .region         (region),
        .commit_en      (commit_en),
        .otp_commit_now (otp_set)
    );

    wp_otp_flag #(
        .OTP_INIT (OTP_INIT)
    ) u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_now (otp_set),
        .used    (otp_used)
    );

    assign data_ack_en = byte_ok;

endmodule

// File: rtl/wprot_unit_chk.sv
module wprot_unit_chk #(
    parameter int ADDR_W    = 12,
    parameter int BLK_SHIFT = 9,
    localparam int BLKCNT_W = $clog2((1 << (ADDR_W - BLK_SHIFT)) + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          region_sel,
    input logic [ADDR_W-1:0]   byte_addr,
    input logic                wc_pin,
    input logic                crw_pin,
    input logic                ctl_wc_pol,
    input logic                ctl_cr_lock,
    input logic [BLKCNT_W-1:0] ctl_ro_blocks,
    input logic                txn_start,
    input logic                byte_strobe,
    input logic                txn_stop,
    input logic                data_ack_en,
    input logic                commit_en,
    input logic                otp_used
);
    a_r3_main_blocked_by_wc: assert property (@(posedge clk) disable iff (rst)
        (region_sel == 2'b00 && (wc_pin != ctl_wc_pol)) |-> !data_ack_en);

    a_r4_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
        (region_sel == 2'b10 && ctl_cr_lock && !crw_pin) |-> !data_ack_en);

    a_r7_page_refused_after_use: assert property (@(posedge clk) disable iff (rst)
        (region_sel == 2'b01 && otp_used) |-> !data_ack_en);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        !$fell(otp_used));

    a_r7_flag_rise_with_commit: assert property (@(posedge clk) disable iff (rst)
        $rose(otp_used) |-> commit_en);

    a_r6_commit_follows_stop: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> $past(txn_stop));

    a_r6_commit_single_cycle: assert property (@(posedge clk) disable iff (rst)
        commit_en |=> !commit_en);

    a_r9_unused_region_nack: assert property (@(posedge clk) disable iff (rst)
        (region_sel == 2'b11) |-> !data_ack_en);

    a_r5_whole_array_zone: assert property (@(posedge clk) disable iff (rst)
        (region_sel == 2'b00 && ctl_ro_blocks >= BLKCNT_W'(1 << (ADDR_W - BLK_SHIFT)))
            |-> !data_ack_en);

    logic unused_ok;
    assign unused_ok = ^{byte_addr, txn_start, byte_strobe};

endmodule

bind wprot_unit wprot_unit_chk #(
    .ADDR_W    (ADDR_W),
    .BLK_SHIFT (BLK_SHIFT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .region_sel    (region_sel),
    .byte_addr     (byte_addr),
    .wc_pin        (wc_pin),
    .crw_pin       (crw_pin),
    .ctl_wc_pol    (ctl_wc_pol),
    .ctl_cr_lock   (ctl_cr_lock),
    .ctl_ro_blocks (ctl_ro_blocks),
    .txn_start     (txn_start),
    .byte_strobe   (byte_strobe),
    .txn_stop      (txn_stop),
    .data_ack_en   (data_ack_en),
    .commit_en     (commit_en),
    .otp_used      (otp_used)
);

// File: tb/wprot_unit_bench.sv
module wprot_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  region_sel;
    logic [11:0] byte_addr;
    logic        wc_pin, crw_pin, ctl_wc_pol, ctl_cr_lock;
    logic [3:0]  ctl_ro_blocks;
    logic        txn_start, byte_strobe, txn_stop;
    logic        data_ack_en, commit_en, otp_used;

    int errors = 0;
    int checks = 0;
    bit model_used = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wprot_unit u_wprot_unit (
        .clk(clk), .rst(rst), .region_sel(region_sel), .byte_addr(byte_addr),
        .wc_pin(wc_pin), .crw_pin(crw_pin), .ctl_wc_pol(ctl_wc_pol),
        .ctl_cr_lock(ctl_cr_lock), .ctl_ro_blocks(ctl_ro_blocks),
        .txn_start(txn_start), .byte_strobe(byte_strobe), .txn_stop(txn_stop),
        .data_ack_en(data_ack_en), .commit_en(commit_en), .otp_used(otp_used)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_ack(input logic [1:0] rgn, input logic [11:0] addr);
        bit wca = ctl_wc_pol ? !wc_pin : wc_pin;
        case (rgn)
            2'b00: return !wca && ((int'(addr) / 512) + int'(ctl_ro_blocks) < 8);
            2'b01: return !wca && !model_used;
            2'b10: return !ctl_cr_lock || crw_pin;
            default: return 1'b0;
        endcase
    endfunction

    task automatic idle_inputs();
        txn_start = 0; byte_strobe = 0; txn_stop = 0;
    endtask

    // Present one byte combinationally and compare the ack decision.
    task automatic probe(input logic [1:0] rgn, input logic [11:0] addr, input string req);
        @(negedge clk);
        region_sel = rgn; byte_addr = addr;
        #1;
        chk(data_ack_en == exp_ack(rgn, addr), req, data_ack_en, exp_ack(rgn, addr));
    endtask

    // Full transaction: start, nb bytes, stop; checks acks, commit and flag.
    task automatic run_write(input logic [1:0] rgn, input logic [11:0] addr,
                             input int nb, input string req);
        bit any = 0;
        bit e;
        @(negedge clk);
        region_sel = rgn; byte_addr = addr; txn_start = 1;
        @(negedge clk);
        txn_start = 0;
        for (int i = 0; i < nb; i++) begin
            byte_strobe = 1; byte_addr = addr + 12'(i);
            #1;
            e = exp_ack(rgn, byte_addr);
            chk(data_ack_en == e, req, data_ack_en, e);
            any |= e;
            @(negedge clk);
        end
        byte_strobe = 0; txn_stop = 1;
        @(negedge clk);
        txn_stop = 0;
        if (any && rgn == 2'b01) model_used = 1'b1;
        #1;
        chk(commit_en == any, "R6 commit after stop", commit_en, any);
        chk(otp_used == model_used, "R7 flag with commit", otp_used, model_used);
        @(negedge clk);
        #1;
        chk(commit_en == 1'b0, "R6 single-cycle commit", commit_en, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_used = 1'b0;
        #1;
        chk(commit_en == 0, "R8 reset commit", commit_en, 0);
        chk(otp_used == 0, "R8 reset flag", otp_used, 0);
    endtask

    task automatic t_main_basic();
        wc_pin = 0; ctl_wc_pol = 0; ctl_ro_blocks = 0;
        probe(2'b00, 12'h000, "R1 main low");
        probe(2'b00, 12'hFFF, "R1 main top");
        run_write(2'b00, 12'h100, 3, "R1 main write");
    endtask

    task automatic t_polarity();
        ctl_ro_blocks = 0;
        wc_pin = 1; ctl_wc_pol = 0;
        probe(2'b00, 12'h010, "R2 pol0 pin high blocks");
        probe(2'b01, 12'h000, "R3 wc blocks page");
        probe(2'b10, 12'h000, "R3 ctrl unaffected by wc");
        run_write(2'b00, 12'h020, 2, "R3 refused write no commit");
        wc_pin = 0; ctl_wc_pol = 1;
        probe(2'b00, 12'h010, "R2 pol1 pin low blocks");
        wc_pin = 1;
        probe(2'b00, 12'h010, "R2 pol1 pin high allows");
        wc_pin = 0; ctl_wc_pol = 0;
        probe(2'b00, 12'h010, "R2 floating-low pin allows");
    endtask

    task automatic t_ctrl_lock();
        for (int m = 0; m < 4; m++) begin
            ctl_cr_lock = m[1]; crw_pin = m[0];
            probe(2'b10, 12'h000, "R4 ctrl lock/pin");
        end
        ctl_cr_lock = 1; crw_pin = 0;
        run_write(2'b10, 12'h000, 1, "R4 locked ctrl no commit");
        ctl_cr_lock = 0;
        run_write(2'b10, 12'h000, 1, "R4 unlocked ctrl commit");
    endtask

    task automatic t_rozone();
        wc_pin = 0; ctl_wc_pol = 0;
        for (int n = 0; n <= 9; n++) begin
            ctl_ro_blocks = 4'(n);
            for (int b = 0; b < 8; b++) begin
                probe(2'b00, 12'(b * 512), "R5 zone block start");
                probe(2'b00, 12'(b * 512 + 511), "R5 zone block end");
            end
        end
        ctl_ro_blocks = 4'd15;
        probe(2'b00, 12'h000, "R5 zone saturate");
        ctl_ro_blocks = 4'd2;
        run_write(2'b00, 12'hBFE, 4, "R5 write crossing zone");
        ctl_ro_blocks = 0;
    endtask

    task automatic t_bad_region();
        probe(2'b11, 12'h000, "R9 unused region");
        run_write(2'b11, 12'h000, 2, "R9 unused region no commit");
    endtask

    task automatic t_otp();
        wc_pin = 1; ctl_wc_pol = 0;
        run_write(2'b01, 12'h000, 2, "R7 refused page leaves flag");
        wc_pin = 0;
        probe(2'b01, 12'h005, "R7 page open before use");
        run_write(2'b01, 12'h000, 4, "R7 first page program");
        probe(2'b01, 12'h003, "R7 page refused after use");
        run_write(2'b01, 12'h000, 1, "R7 second page write refused");
        probe(2'b00, 12'h000, "R7 main still open");
    endtask

    task automatic t_start_clears();
        // Accepted byte then a restart: the earlier byte must not commit.
        wc_pin = 0; ctl_wc_pol = 0; ctl_ro_blocks = 0;
        @(negedge clk);
        region_sel = 2'b00; byte_addr = 12'h040; byte_strobe = 1;
        @(negedge clk);
        byte_strobe = 0; txn_start = 1;
        @(negedge clk);
        txn_start = 0; txn_stop = 1;
        @(negedge clk);
        txn_stop = 0;
        #1;
        chk(commit_en == 0, "R6 start clears pending", commit_en, 0);
    endtask

    initial begin
        rst = 1; idle_inputs();
        region_sel = 0; byte_addr = 0; wc_pin = 0; crw_pin = 0;
        ctl_wc_pol = 0; ctl_cr_lock = 0; ctl_ro_blocks = 0;
        do_reset();
        t_main_basic();
        t_polarity();
        t_ctrl_lock();
        t_rozone();
        t_bad_region();
        t_start_clears();
        t_otp();
        do_reset();
        probe(2'b01, 12'h000, "R8 flag reloaded from parameter");
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule